// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupt Detection

This block is one bank of sixteen general-purpose pins. Four of these banks make up a 64-pin port. Software controls the bank through a small register interface with 16-bit data. Each pin has these per-pin settings:

- a driven value;
- an output-enable;
- an alternate-function select;
- an interrupt mask;
- a wake mask.

Software can also read the pin's synchronised input level.

Every pin can raise an interrupt in one of two ways:

- on an edge, rising or falling;
- on a level, high or low.

Three per-pin registers make this choice: trigger kind, edge polarity and level polarity. There is no mode that detects both edges. To see both edges, firmware flips a pin's edge polarity after each event.

When an unmasked pin fires, its bit in a sticky status register is set. The bank interrupt output is the registered OR of the status bits whose pins are unmasked. A wake output is the registered OR of the status bits whose pins are allowed to wake the system.

Top module: `gpio_bank`

## Requirements
- R1: After reset the interrupt mask (offset 3) reads 0xFFFF. Every other register, the status register and irq_o and wake_o read 0.
- R2: Register offsets are fixed as follows: 0 output value, 1 direction, 2 alternate select, 3 interrupt mask, 4 wake mask, 5 trigger kind, 6 edge polarity, 7 level polarity, 8 status, 9 pin level (read-only). Each writable register reads back what was written. The output value drives pad_out_o. The alternate select drives alt_sel_o. Direction drives pad_oe_o, where 1 means output and 0 means input.
- R3: Pin level (offset 9) returns pin_i after a two-flop synchroniser. A change is visible after the second rising clock edge.
- R4: With trigger kind 1 (edge) and edge polarity 1, an unmasked pin sets its status bit on a 0-to-1 transition of its synchronised level. It does not set the bit while the level is steady.
- R5: With edge polarity 0, a 1-to-0 transition sets the status bit. Rewriting the polarity takes effect on the next sampled edge.
- R6: With trigger kind 0 (level), an unmasked pin sets its status bit on every cycle its level matches the level polarity, where 1 means high and 0 means low.
- R7: A pin whose mask bit is 1 never sets its status bit.
- R8: A write to status keeps only the bits where the written data is 1, so writing 0 clears the whole bank. An event in the same cycle as the write leaves its bit set.
- R9: irq_o is 1 one cycle after any status bit is set while that pin is unmasked. Otherwise irq_o is 0.
- R10: wake_o is 1 one cycle after any status bit is set while that pin's wake-mask bit is 0. Otherwise wake_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| pin_i | input | 16 | Asynchronous pin levels from the pads |
| pad_out_o | output | 16 | Value driven onto the pads |
| pad_oe_o | output | 16 | Pad output enable |
| alt_sel_o | output | 16 | Alternate-function select per pin |
| irq_o | output | 1 | Bank interrupt |
| wake_o | output | 1 | Bank wake request |

## Verification
The hardest case to reach from the ports is a clearing write to status landing in the same cycle as a new event. With edge triggers that window is a single cycle behind the synchroniser. The bench therefore uses a level-triggered pin held at its active level: that pin produces an event on every cycle, so any clearing write must coincide with one. The status bit is then read back after the write. Partial clears and the masking of an already-set bit are reached in the same way, by holding levels on several pins and then changing the mask before writing status.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned NPIN = 16;
  localparam int unsigned AW   = 4;

  typedef enum logic [AW-1:0] {
    REG_OUT  = 4'd0,
    REG_DIR  = 4'd1,
    REG_ALT  = 4'd2,
    REG_MASK = 4'd3,
    REG_WAKE = 4'd4,
    REG_TRIG = 4'd5,
    REG_EPOL = 4'd6,
    REG_LPOL = 4'd7,
    REG_STAT = 4'd8,
    REG_PIN  = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int unsigned NPIN = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] trig_i,
  input  logic [NPIN-1:0] epol_i,
  input  logic [NPIN-1:0] lpol_i,
  input  logic [NPIN-1:0] mask_i,
  output logic [NPIN-1:0] event_o
);
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic rise, fall, hit;
    assign rise = lvl_i[p] & ~prev_q[p];
    assign fall = ~lvl_i[p] & prev_q[p];
    always_comb begin
      if (trig_i[p]) hit = epol_i[p] ? rise : fall;
      else           hit = lpol_i[p] ? lvl_i[p] : ~lvl_i[p];
    end
    assign event_o[p] = hit & ~mask_i[p];
  end
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int unsigned NPIN = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_we_i,
  input  logic [NPIN-1:0] keep_i,
  input  logic [NPIN-1:0] event_i,
  input  logic [NPIN-1:0] mask_i,
  input  logic [NPIN-1:0] wake_mask_i,
  output logic [NPIN-1:0] status_o,
  output logic            irq_o,
  output logic            wake_o
);
  logic [NPIN-1:0] status_q, status_d;

  // new events override a same-cycle clearing write
  always_comb begin
    status_d = clr_we_i ? (status_q & keep_i) : status_q;
    status_d = status_d | event_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_o    <= 1'b0;
      wake_o   <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_o    <= |(status_q & ~mask_i);
      wake_o   <= |(status_q & ~wake_mask_i);
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic [NPIN-1:0] rdata_o,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] pad_out_o,
  output logic [NPIN-1:0] pad_oe_o,
  output logic [NPIN-1:0] alt_sel_o,
  output logic            irq_o,
  output logic            wake_o
);
  logic [NPIN-1:0] out_q, dir_q, alt_q, mask_q, wake_mask_q;
  logic [NPIN-1:0] trig_q, epol_q, lpol_q;
  logic [NPIN-1:0] lvl, evt, status_q;
  logic            clr_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q       <= '0;
      dir_q       <= '0;
      alt_q       <= '0;
      mask_q      <= '1;
      wake_mask_q <= '0;
      trig_q      <= '0;
      epol_q      <= '0;
      lpol_q      <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_OUT:  out_q       <= wdata_i;
        REG_DIR:  dir_q       <= wdata_i;
        REG_ALT:  alt_q       <= wdata_i;
        REG_MASK: mask_q      <= wdata_i;
        REG_WAKE: wake_mask_q <= wdata_i;
        REG_TRIG: trig_q      <= wdata_i;
        REG_EPOL: epol_q      <= wdata_i;
        REG_LPOL: lpol_q      <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_we = we_i && (addr_i == REG_STAT);

  gpio_sync #(.WIDTH(NPIN), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  gpio_detect #(.NPIN(NPIN)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .trig_i (trig_q),
    .epol_i (epol_q),
    .lpol_i (lpol_q),
    .mask_i (mask_q),
    .event_o(evt)
  );

  gpio_status #(.NPIN(NPIN)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_we_i   (clr_we),
    .keep_i     (wdata_i),
    .event_i    (evt),
    .mask_i     (mask_q),
    .wake_mask_i(wake_mask_q),
    .status_o   (status_q),
    .irq_o      (irq_o),
    .wake_o     (wake_o)
  );

  always_comb begin
    case (addr_i)
      REG_OUT:  rdata_o = out_q;
      REG_DIR:  rdata_o = dir_q;
      REG_ALT:  rdata_o = alt_q;
      REG_MASK: rdata_o = mask_q;
      REG_WAKE: rdata_o = wake_mask_q;
      REG_TRIG: rdata_o = trig_q;
      REG_EPOL: rdata_o = epol_q;
      REG_LPOL: rdata_o = lpol_q;
      REG_STAT: rdata_o = status_q;
      REG_PIN:  rdata_o = lvl;
      default:  rdata_o = '0;
    endcase
  end

  assign pad_out_o = out_q;
  assign pad_oe_o  = dir_q;
  assign alt_sel_o = alt_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic [NPIN-1:0] status_q,
  input logic [NPIN-1:0] mask_q,
  input logic [NPIN-1:0] wake_mask_q,
  input logic [NPIN-1:0] pad_oe_o,
  input logic            irq_o,
  input logic            wake_o
);
  logic clr_we;
  assign clr_we = we_i && (addr_i == REG_STAT);

  // R8: without a status write, no set bit is lost
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R7: masked pins never become set
  p_masked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & $past(mask_q)) == '0));

  p_irq_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_q & ~mask_q)) |=> irq_o);

  p_irq_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(status_q & ~mask_q)) |=> !irq_o);

  p_wake_hi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_q & ~wake_mask_q)) |=> wake_o);

  p_oe_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pad_oe_o));
endmodule

bind gpio_bank gpio_bank_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .wake_mask_q(wake_mask_q),
  .pad_oe_o   (pad_oe_o),
  .irq_o      (irq_o),
  .wake_o     (wake_o)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] A_OUT = 4'd0, A_DIR = 4'd1, A_ALT = 4'd2, A_MASK = 4'd3,
                         A_WAKE = 4'd4, A_TRIG = 4'd5, A_EPOL = 4'd6,
                         A_LPOL = 4'd7, A_STAT = 4'd8, A_PIN = 4'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] pins = '0;
  logic [15:0] pad_out, pad_oe, alt_sel;
  logic        irq, wake;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .alt_sel_o(alt_sel), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [15:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 mask", A_MASK, 16'hFFFF);
    rd_chk("R1 out", A_OUT, 16'h0000);
    rd_chk("R1 trig", A_TRIG, 16'h0000);
    rd_chk("R1 stat", A_STAT, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 wake", {15'd0, wake}, 16'd0);
  endtask

  task automatic t_regs;
    wr(A_OUT, 16'hA5A5);
    wr(A_DIR, 16'h0FF0);
    wr(A_ALT, 16'h1234);
    wr(A_WAKE, 16'h00C3);
    chk("R2 pad_out", pad_out, 16'hA5A5);
    chk("R2 pad_oe", pad_oe, 16'h0FF0);
    chk("R2 alt_sel", alt_sel, 16'h1234);
    rd_chk("R2 dir rb", A_DIR, 16'h0FF0);
    rd_chk("R2 wake rb", A_WAKE, 16'h00C3);
    wr(A_WAKE, 16'h0000);
  endtask

  task automatic t_sync;
    @(negedge clk);
    pins = 16'h8001;
    @(negedge clk);
    rd_chk("R3 one edge", A_PIN, 16'h0000);
    @(negedge clk);
    rd_chk("R3 two edges", A_PIN, 16'h8001);
    pins = 16'h0000;
    wait_cyc(3);
  endtask

  task automatic t_rising;
    wr(A_TRIG, 16'h0001);
    wr(A_EPOL, 16'h0001);
    wr(A_MASK, 16'hFFFE);
    wait_cyc(3);
    wr(A_STAT, 16'h0000);
    rd_chk("R4 quiet before edge", A_STAT, 16'h0000);
    pins[0] = 1'b1;
    wait_cyc(4);
    rd_chk("R4 rising sets", A_STAT, 16'h0001);
    chk("R9 irq on", {15'd0, irq}, 16'd1);
    wr(A_STAT, 16'h0000);
    wait_cyc(3);
    rd_chk("R4 steady high no refire", A_STAT, 16'h0000);
    chk("R9 irq off", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_falling;
    wr(A_EPOL, 16'h0000);
    wait_cyc(2);
    rd_chk("R5 flip alone no event", A_STAT, 16'h0000);
    pins[0] = 1'b0;
    wait_cyc(4);
    rd_chk("R5 falling sets", A_STAT, 16'h0001);
    wr(A_STAT, 16'h0000);
    wr(A_MASK, 16'hFFFF);
  endtask

  task automatic t_level;
    wr(A_LPOL, 16'h0004);
    wr(A_MASK, 16'hFFFB);
    wait_cyc(3);
    rd_chk("R6 inactive level", A_STAT, 16'h0000);
    pins[2] = 1'b1;
    wait_cyc(4);
    rd_chk("R6 high sets", A_STAT, 16'h0004);
    wr(A_STAT, 16'h0000);
    rd_chk("R8 event beats clear", A_STAT, 16'h0004);
    pins[2] = 1'b0;
    wait_cyc(4);
    wr(A_STAT, 16'h0000);
    rd_chk("R6 clears once inactive", A_STAT, 16'h0000);
    wr(A_LPOL, 16'h0000);
    wait_cyc(2);
    rd_chk("R6 low level sets", A_STAT, 16'h0004);
    wr(A_MASK, 16'hFFFF);
    wr(A_STAT, 16'h0000);
    rd_chk("R7 masked after clear", A_STAT, 16'h0000);
  endtask

  task automatic t_mask;
    wait_cyc(4);
    rd_chk("R7 masked low pins quiet", A_STAT, 16'h0000);
    chk("R7 irq quiet", {15'd0, irq}, 16'd0);
    wr(A_MASK, 16'hFFF7);
    wait_cyc(2);
    rd_chk("R7 unmasked sets", A_STAT, 16'h0008);
    chk("R9 irq unmasked", {15'd0, irq}, 16'd1);
    wr(A_MASK, 16'hFFFF);
    wait_cyc(1);
    chk("R9 irq drops when masked", {15'd0, irq}, 16'd0);
    rd_chk("R9 status kept", A_STAT, 16'h0008);
    wr(A_STAT, 16'h0000);
  endtask

  task automatic t_partial;
    wr(A_MASK, 16'hFFCF);
    wait_cyc(2);
    wr(A_MASK, 16'hFFFF);
    rd_chk("R8 two set", A_STAT, 16'h0030);
    wr(A_STAT, 16'h0010);
    rd_chk("R8 partial keep", A_STAT, 16'h0010);
  endtask

  task automatic t_wake;
    wait_cyc(1);
    chk("R10 wake on", {15'd0, wake}, 16'd1);
    wr(A_WAKE, 16'h0010);
    wait_cyc(1);
    chk("R10 wake blocked", {15'd0, wake}, 16'd0);
    wr(A_WAKE, 16'h0000);
    wr(A_STAT, 16'h0000);
    wait_cyc(1);
    chk("R10 wake after clear", {15'd0, wake}, 16'd0);
  endtask

  initial begin
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_regs();
    t_sync();
    t_rising();
    t_falling();
    t_level();
    t_mask();
    t_partial();
    t_wake();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule